// File: doc/BRIEF.md
# Single-Wire Bus Device ID Enumerator

This block is the master-side controller that discovers the 64-bit identifiers of every device on a shared open-drain single-wire bus. It does this by elimination. It sits above a bit-level slot engine that owns the analog timing. It asks that engine for bus resets, single-bit writes and single-bit reads through a request/done handshake. The slot engine returns either the presence result or the sampled bus level.

A pulse on `start` launches a complete enumeration. Each pass resets the bus and sends the search command byte. It then walks the 64 identifier positions, least significant first. At each position it reads the bit and its complement, both as wired-AND values over all devices still taking part. It then writes back the branch it has chosen, and the devices that disagree drop out. A single branch-point record carries over from pass to pass, so each pass yields exactly one new identifier. That identifier is shown on `idOut` with a one-cycle `idValid` strobe. The enumeration ends when a pass takes no new 0-branch at a conflict. When `intrOnly` is set at start, the alternate command is used, so only devices with a pending interrupt answer.

Top module: `wire_id_search`

## Requirements
- R1: After reset the block is idle: `slotReq`, `idValid`, `searchDone` and `searchErr` are low.
- R2: Every pass begins with a bus-reset request (`slotOp` = 0). If that request completes with `slotRdBit` = 0 (no presence), the block raises `searchErr` and `searchDone` and issues no further requests.
- R3: After a reset with presence, the command byte goes out as 8 write requests (`slotOp` = 1), least significant bit first. The byte is F0h when `intrOnly` was low at start and ECh when it was high.
- R4: For each of the 64 identifier positions, taken from bit 0 upward, the block issues two read requests (`slotOp` = 2) and then one write request, in that order.
- R5: When the two reads at a position differ, the written bit equals the first read value.
- R6: When both reads are 0 (a conflict), the written bit is the previous pass's bit at that position if the position lies below the stored branch point. It is 1 at the branch point and 0 above it. Positions are counted 1 to 64, and a branch point of 0 means none.
- R7: At the end of each pass, `idOut` carries the 64 written bits (bit i = bit written at position i+1) while `idValid` is high for exactly one cycle.
- R8: After a pass in which no conflict resolved to 0, `searchDone` rises with `searchErr` low. Every participating device has then been reported exactly once, in ascending order of its bit-reversed identifier.
- R9: If both reads at a position return 1, the block raises `searchErr` and `searchDone` and stops issuing requests.
- R10: While `slotReq` is high and `slotDone` is low, the request, `slotOp` and `slotWrBit` stay unchanged into the next cycle.
- R11: A `start` pulse while idle clears `searchDone` and `searchErr` and raises a reset request in the next cycle, even after an earlier error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a full enumeration (used while idle) |
| intrOnly | input | 1 | Select the interrupt-only command for this enumeration |
| slotReq | output | 1 | Request to the slot engine |
| slotOp | output | 2 | Requested slot: 0 reset, 1 write, 2 read |
| slotWrBit | output | 1 | Bit value for a write slot |
| slotDone | input | 1 | One-cycle completion from the slot engine |
| slotRdBit | input | 1 | Presence (reset) or sampled level (read), valid with slotDone |
| idOut | output | 64 | Identifier found in the latest pass |
| idValid | output | 1 | One-cycle strobe marking idOut |
| searchDone | output | 1 | Enumeration finished (held until next start) |
| searchErr | output | 1 | Enumeration aborted: no presence or empty bit pair |

## Verification
The assertions assume that the slot engine pulses `slotDone` for a single cycle, only while `slotReq` is high. They also assume that `slotRdBit` is meaningful in that cycle, and that `start` is raised only while the block is idle. The bench's bus model meets these terms by construction. It waits two cycles on each request, then completes it with a one-cycle done and a freshly computed wired-AND level. It lowers done before it looks at the next request. The test tasks pulse `start` only after `searchDone` has been seen.

// File: rtl/wire_id_search_pkg.sv
package wire_id_search_pkg;

  typedef enum logic [1:0] {
    SLOT_RESET = 2'd0,
    SLOT_WRITE = 2'd1,
    SLOT_READ  = 2'd2
  } slotOp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrAll;
    logic passInit;
    logic cmdShift;
    logic latchFirst;
    logic latchSecond;
    logic bitStep;
    logic passEnd;
  } ctlStrobe_t;

endpackage

// File: rtl/wire_id_search_dp.sv
module wire_id_search_dp
  import wire_id_search_pkg::*;
#(
  parameter int IdBits    = 64,
  parameter int CmdBits   = 8,
  parameter logic [CmdBits-1:0] CmdNormal = 8'hF0,
  parameter logic [CmdBits-1:0] CmdIntr   = 8'hEC
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strb,
  input  logic              intrOnly,
  input  logic              slotRdBit,
  output logic              cmdBit,
  output logic              cmdLast,
  output logic              dirBit,
  output logic              idxLast,
  output logic              pairEmpty,
  output logic              branchLeft,
  output logic [IdBits-1:0] idOut,
  output logic              idValid
);

  localparam int PosW  = $clog2(IdBits + 1);
  localparam int IdxW  = $clog2(IdBits);
  localparam int CntW  = (CmdBits > 1) ? $clog2(CmdBits) : 1;

  logic [IdBits-1:0]  romReg;
  logic [PosW-1:0]    lastDisc;
  logic [PosW-1:0]    lastZero;
  logic [PosW-1:0]    lastZeroNext;
  logic [PosW-1:0]    pos;
  logic [IdxW-1:0]    idx;
  logic [CmdBits-1:0] cmdReg;
  logic [CntW-1:0]    cmdCnt;
  logic               modeReg;
  logic               firstBit;
  logic               secondBit;
  logic               validReg;
  logic               conflict;
  logic               useIntr;

  assign pos      = PosW'(idx) + PosW'(1);
  assign conflict = !firstBit && !secondBit;
  assign useIntr  = strb.clrAll ? intrOnly : modeReg;

  always_comb begin
    if (!conflict)            dirBit = firstBit;
    else if (pos < lastDisc)  dirBit = romReg[idx];
    else if (pos == lastDisc) dirBit = 1'b1;
    else                      dirBit = 1'b0;
  end

  assign lastZeroNext = (conflict && !dirBit) ? pos : lastZero;
  assign branchLeft   = (lastZeroNext != '0);
  assign cmdBit       = cmdReg[0];
  assign cmdLast      = (cmdCnt == CntW'(CmdBits - 1));
  assign idxLast      = (idx == IdxW'(IdBits - 1));
  assign pairEmpty    = firstBit && slotRdBit;
  assign idOut        = romReg;
  assign idValid      = validReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romReg    <= '0;
      lastDisc  <= '0;
      lastZero  <= '0;
      idx       <= '0;
      cmdReg    <= '0;
      cmdCnt    <= '0;
      modeReg   <= 1'b0;
      firstBit  <= 1'b0;
      secondBit <= 1'b0;
      validReg  <= 1'b0;
    end else begin
      validReg <= strb.passEnd;
      if (strb.clrAll) begin
        lastDisc <= '0;
        modeReg  <= intrOnly;
      end
      if (strb.cmdShift) begin
        cmdReg <= cmdReg >> 1;
        cmdCnt <= cmdCnt + CntW'(1);
      end
      if (strb.latchFirst)  firstBit  <= slotRdBit;
      if (strb.latchSecond) secondBit <= slotRdBit;
      if (strb.bitStep) begin
        romReg[idx] <= dirBit;
        lastZero    <= lastZeroNext;
        idx         <= idx + IdxW'(1);
      end
      if (strb.passEnd) lastDisc <= lastZeroNext;
      if (strb.passInit) begin
        idx      <= '0;
        lastZero <= '0;
        cmdCnt   <= '0;
        cmdReg   <= useIntr ? CmdIntr : CmdNormal;
      end
    end
  end

endmodule

// File: rtl/wire_id_search_ctrl.sv
module wire_id_search_ctrl
  import wire_id_search_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       slotDone,
  input  logic       slotRdBit,
  input  logic       cmdBit,
  input  logic       cmdLast,
  input  logic       dirBit,
  input  logic       idxLast,
  input  logic       pairEmpty,
  input  logic       branchLeft,
  output ctlStrobe_t strb,
  output logic       slotReq,
  output slotOp_t    slotOp,
  output logic       slotWrBit,
  output logic       searchDone,
  output logic       searchErr
);

  typedef enum logic [2:0] {
    S_IDLE, S_RESET, S_CMD, S_RD1, S_RD2, S_WR
  } state_t;

  state_t state, nextState;
  logic   doneReg, errReg, nextDone, nextErr;

  always_comb begin
    nextState = state;
    nextDone  = doneReg;
    nextErr   = errReg;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.clrAll   = 1'b1;
          strb.passInit = 1'b1;
          nextDone      = 1'b0;
          nextErr       = 1'b0;
          nextState     = S_RESET;
        end
      end
      S_RESET: begin
        if (slotDone) begin
          if (!slotRdBit) begin
            nextDone  = 1'b1;
            nextErr   = 1'b1;
            nextState = S_IDLE;
          end else begin
            nextState = S_CMD;
          end
        end
      end
      S_CMD: begin
        if (slotDone) begin
          strb.cmdShift = 1'b1;
          if (cmdLast) nextState = S_RD1;
        end
      end
      S_RD1: begin
        if (slotDone) begin
          strb.latchFirst = 1'b1;
          nextState       = S_RD2;
        end
      end
      S_RD2: begin
        if (slotDone) begin
          strb.latchSecond = 1'b1;
          if (pairEmpty) begin
            nextDone  = 1'b1;
            nextErr   = 1'b1;
            nextState = S_IDLE;
          end else begin
            nextState = S_WR;
          end
        end
      end
      S_WR: begin
        if (slotDone) begin
          strb.bitStep = 1'b1;
          if (idxLast) begin
            strb.passEnd = 1'b1;
            if (branchLeft) begin
              strb.passInit = 1'b1;
              nextState     = S_RESET;
            end else begin
              nextDone  = 1'b1;
              nextState = S_IDLE;
            end
          end else begin
            nextState = S_RD1;
          end
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_comb begin
    slotReq   = (state != S_IDLE);
    slotWrBit = 1'b0;
    unique case (state)
      S_RESET:     slotOp = SLOT_RESET;
      S_RD1, S_RD2: slotOp = SLOT_READ;
      S_CMD: begin
        slotOp    = SLOT_WRITE;
        slotWrBit = cmdBit;
      end
      S_WR: begin
        slotOp    = SLOT_WRITE;
        slotWrBit = dirBit;
      end
      default:     slotOp = SLOT_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      doneReg <= 1'b0;
      errReg  <= 1'b0;
    end else begin
      state   <= nextState;
      doneReg <= nextDone;
      errReg  <= nextErr;
    end
  end

  assign searchDone = doneReg;
  assign searchErr  = errReg;

endmodule

// File: rtl/wire_id_search.sv
module wire_id_search
  import wire_id_search_pkg::*;
#(
  parameter int IdBits  = 64,
  parameter int CmdBits = 8,
  parameter logic [CmdBits-1:0] CmdNormal = 8'hF0,
  parameter logic [CmdBits-1:0] CmdIntr   = 8'hEC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              intrOnly,
  output logic              slotReq,
  output logic [1:0]        slotOp,
  output logic              slotWrBit,
  input  logic              slotDone,
  input  logic              slotRdBit,
  output logic [IdBits-1:0] idOut,
  output logic              idValid,
  output logic              searchDone,
  output logic              searchErr
);

  ctlStrobe_t strb;
  slotOp_t    opSel;
  logic cmdBit, cmdLast, dirBit, idxLast, pairEmpty, branchLeft;

  wire_id_search_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .slotDone   (slotDone),
    .slotRdBit  (slotRdBit),
    .cmdBit     (cmdBit),
    .cmdLast    (cmdLast),
    .dirBit     (dirBit),
    .idxLast    (idxLast),
    .pairEmpty  (pairEmpty),
    .branchLeft (branchLeft),
    .strb       (strb),
    .slotReq    (slotReq),
    .slotOp     (opSel),
    .slotWrBit  (slotWrBit),
    .searchDone (searchDone),
    .searchErr  (searchErr)
  );

  wire_id_search_dp #(
    .IdBits    (IdBits),
    .CmdBits   (CmdBits),
    .CmdNormal (CmdNormal),
    .CmdIntr   (CmdIntr)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .intrOnly   (intrOnly),
    .slotRdBit  (slotRdBit),
    .cmdBit     (cmdBit),
    .cmdLast    (cmdLast),
    .dirBit     (dirBit),
    .idxLast    (idxLast),
    .pairEmpty  (pairEmpty),
    .branchLeft (branchLeft),
    .idOut      (idOut),
    .idValid    (idValid)
  );

  assign slotOp = opSel;

endmodule

// File: rtl/wire_id_search_chk.sv
module wire_id_search_chk (
  input logic       clk,
  input logic       rstN,
  input logic       start,
  input logic       slotReq,
  input logic [1:0] slotOp,
  input logic       slotWrBit,
  input logic       slotDone,
  input logic       idValid,
  input logic       searchDone,
  input logic       searchErr
);

  // R10: request held steady until completion
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && !slotDone) |=> (slotReq && $stable(slotOp) && $stable(slotWrBit)));

  // R7: found-ID strobe lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    idValid |=> !idValid);

  // R8: a finished search makes no bus requests
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    searchDone |-> !slotReq);

  // R9: an error always ends the search
  p_err_ends_r9: assert property (@(posedge clk) disable iff (!rstN)
    searchErr |-> searchDone);

  // R11: start from idle clears flags and opens with a bus reset
  p_start_reset_r11: assert property (@(posedge clk) disable iff (!rstN)
    (start && !slotReq) |=> (slotReq && slotOp == 2'd0 && !searchDone && !searchErr));

  // R2: a pass opens with a bus reset
  p_first_op_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(slotReq) |-> (slotOp == 2'd0));

endmodule

bind wire_id_search wire_id_search_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .slotReq    (slotReq),
  .slotOp     (slotOp),
  .slotWrBit  (slotWrBit),
  .slotDone   (slotDone),
  .idValid    (idValid),
  .searchDone (searchDone),
  .searchErr  (searchErr)
);

// File: tb/wire_id_search_test.sv
module wire_id_search_test;

  localparam int ClkPeriod = 10;
  localparam int MaxDev    = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        intrOnly = 1'b0;
  logic        slotReq;
  logic [1:0]  slotOp;
  logic        slotWrBit;
  logic        slotDone = 1'b0;
  logic        slotRdBit = 1'b0;
  logic [63:0] idOut;
  logic        idValid;
  logic        searchDone;
  logic        searchErr;

  int checks = 0;
  int fails  = 0;

  wire_id_search uut (
    .clk(clk), .rstN(rstN), .start(start), .intrOnly(intrOnly),
    .slotReq(slotReq), .slotOp(slotOp), .slotWrBit(slotWrBit),
    .slotDone(slotDone), .slotRdBit(slotRdBit),
    .idOut(idOut), .idValid(idValid),
    .searchDone(searchDone), .searchErr(searchErr)
  );

  always #(ClkPeriod/2) clk = ~clk;

  // ---- device population and bus model ----
  logic [63:0] devId [MaxDev];
  bit          devPresent [MaxDev];
  bit          devIntr [MaxDev];
  bit          active [MaxDev];
  int          dropAt = -1;
  int          waitCnt = 0;
  int          cmdCnt = 0;
  logic [7:0]  cmdByte = 8'h00;
  int          bitPos = 0;
  int          subStep = 0;
  int          resetCount = 0;
  int          protoErr = 0;
  int          holdErr = 0;
  logic [1:0]  heldOp;
  logic        heldBit;

  logic [63:0] found [16];
  int          nFound = 0;

  task automatic doSlot();
    logic v;
    case (slotOp)
      2'd0: begin
        v = 1'b0;
        for (int d = 0; d < MaxDev; d++) begin
          active[d] = devPresent[d];
          if (devPresent[d]) v = 1'b1;
        end
        cmdCnt = 0; bitPos = 0; subStep = 0;
        resetCount++;
        slotRdBit = v;
      end
      2'd1: begin
        if (cmdCnt < 8) begin
          cmdByte[cmdCnt] = slotWrBit;
          cmdCnt++;
          if (cmdCnt == 8 && cmdByte == 8'hEC)
            for (int d = 0; d < MaxDev; d++) if (!devIntr[d]) active[d] = 0;
        end else begin
          if (subStep != 2) protoErr++;
          for (int d = 0; d < MaxDev; d++)
            if (active[d] && devId[d][bitPos] != slotWrBit) active[d] = 0;
          bitPos++;
          subStep = 0;
        end
        slotRdBit = 1'b0;
      end
      2'd2: begin
        if (cmdCnt < 8 || subStep > 1 || bitPos > 63) protoErr++;
        if (bitPos == dropAt)
          for (int d = 0; d < MaxDev; d++) active[d] = 0;
        v = 1'b1;
        for (int d = 0; d < MaxDev; d++)
          if (active[d] && bitPos < 64)
            v = v & (subStep == 0 ? devId[d][bitPos] : ~devId[d][bitPos]);
        subStep++;
        slotRdBit = v;
      end
      default: protoErr++;
    endcase
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (idValid && nFound < 16) begin
        found[nFound] = idOut;
        nFound++;
      end
      if (slotDone) begin
        slotDone = 1'b0;
        waitCnt = 0;
      end else if (slotReq) begin
        waitCnt++;
        if (waitCnt == 1) begin
          heldOp = slotOp; heldBit = slotWrBit;
        end else if (waitCnt == 2) begin
          if (heldOp != slotOp || heldBit != slotWrBit) holdErr++;
          doSlot();
          slotDone = 1'b1;
        end
      end else begin
        waitCnt = 0;
      end
    end
  end

  // ---- checking helpers ----
  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] bitRev(input logic [63:0] x);
    logic [63:0] r;
    for (int i = 0; i < 64; i++) r[i] = x[63-i];
    return r;
  endfunction

  task automatic clearDevs();
    for (int d = 0; d < MaxDev; d++) begin
      devId[d] = '0; devPresent[d] = 0; devIntr[d] = 0; active[d] = 0;
    end
    dropAt = -1;
  endtask

  task automatic runSearch(input bit intr, input string req11);
    nFound = 0; resetCount = 0; protoErr = 0; holdErr = 0; cmdByte = 8'h00;
    @(negedge clk);
    intrOnly = intr;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(slotReq && slotOp == 2'd0 && !searchDone && !searchErr, req11,
          {60'd0, slotReq, slotOp, searchDone}, {60'd0, 1'b1, 2'd0, 1'b0});
    for (int t = 0; t < 20000; t++) begin
      if (searchDone) break;
      @(negedge clk);
    end
  endtask

  // expected order: ascending bit-reversed value of participants
  task automatic checkFound(input bit intr, input string req);
    logic [63:0] exp [MaxDev];
    int nExp = 0;
    logic [63:0] tmp;
    for (int d = 0; d < MaxDev; d++)
      if (devPresent[d] && (!intr || devIntr[d])) begin
        exp[nExp] = devId[d]; nExp++;
      end
    for (int i = 0; i < nExp; i++)
      for (int j = 0; j + 1 < nExp - i; j++)
        if (bitRev(exp[j]) > bitRev(exp[j+1])) begin
          tmp = exp[j]; exp[j] = exp[j+1]; exp[j+1] = tmp;
        end
    check(nFound == nExp, req, 64'(nFound), 64'(nExp));
    for (int i = 0; i < nExp && i < nFound; i++)
      check(found[i] == exp[i], req, found[i], exp[i]);
    check(resetCount == nExp, "R2 passes", 64'(resetCount), 64'(nExp));
  endtask

  task automatic checkClean(input string req);
    check(protoErr == 0, req, 64'(protoErr), 64'd0);
    check(holdErr == 0, "R10 hold", 64'(holdErr), 64'd0);
  endtask

  // ---- scenarios ----
  task automatic testReset();
    @(negedge clk);
    check(!slotReq && !idValid && !searchDone && !searchErr, "R1 idle",
          {60'd0, slotReq, idValid, searchDone, searchErr}, 64'd0);
  endtask

  task automatic testSingle();
    clearDevs();
    devId[0] = 64'hA5C3_0F10_7E21_9B44; devPresent[0] = 1;
    runSearch(0, "R11 start");
    check(searchDone && !searchErr, "R8 done", {62'd0, searchDone, searchErr}, 64'd2);
    check(cmdByte == 8'hF0, "R3 normal cmd", 64'(cmdByte), 64'hF0);
    checkFound(0, "R5 R7 single");
    checkClean("R4 order");
  endtask

  task automatic testThree();
    clearDevs();
    devId[0] = 64'h0123_4567_89AB_CDEF; devPresent[0] = 1;
    devId[1] = 64'h0123_4567_89AB_CDEE; devPresent[1] = 1;
    devId[2] = 64'hF123_4567_89AB_CDEF; devPresent[2] = 1;
    runSearch(0, "R11 start");
    check(searchDone && !searchErr, "R8 done", {62'd0, searchDone, searchErr}, 64'd2);
    checkFound(0, "R6 R8 three");
    checkClean("R4 order");
  endtask

  task automatic testEdges();
    clearDevs();
    devId[0] = 64'h0000_0000_0000_0000; devPresent[0] = 1;
    devId[1] = 64'h0000_0000_0000_0001; devPresent[1] = 1;
    devId[2] = 64'h8000_0000_0000_0000; devPresent[2] = 1;
    devId[3] = 64'h8000_0000_0000_0001; devPresent[3] = 1;
    runSearch(0, "R11 start");
    check(searchDone && !searchErr, "R8 done", {62'd0, searchDone, searchErr}, 64'd2);
    checkFound(0, "R6 edge bits");
    checkClean("R4 order");
  endtask

  task automatic testIntr();
    clearDevs();
    devId[0] = 64'h1111_2222_3333_4444; devPresent[0] = 1; devIntr[0] = 1;
    devId[1] = 64'h5555_6666_7777_8888; devPresent[1] = 1; devIntr[1] = 0;
    devId[2] = 64'h1111_2222_3333_4445; devPresent[2] = 1; devIntr[2] = 1;
    runSearch(1, "R11 start");
    check(cmdByte == 8'hEC, "R3 intr cmd", 64'(cmdByte), 64'hEC);
    checkFound(1, "R3 intr only");
    checkClean("R4 order");
  endtask

  task automatic testNoDevice();
    clearDevs();
    runSearch(0, "R11 start");
    check(searchDone && searchErr, "R2 no presence", {62'd0, searchDone, searchErr}, 64'd3);
    check(nFound == 0 && resetCount == 1, "R2 stop", 64'(nFound + resetCount), 64'd1);
    repeat (5) @(negedge clk);
    check(!slotReq, "R2 quiet", 64'(slotReq), 64'd0);
  endtask

  task automatic testDrop();
    clearDevs();
    devId[0] = 64'hDEAD_BEEF_0000_1234; devPresent[0] = 1;
    dropAt = 20;
    runSearch(0, "R11 after error");
    check(searchDone && searchErr, "R9 empty pair", {62'd0, searchDone, searchErr}, 64'd3);
    check(nFound == 0 && bitPos == 20, "R9 stop", 64'(bitPos), 64'd20);
    repeat (5) @(negedge clk);
    check(!slotReq, "R9 quiet", 64'(slotReq), 64'd0);
  endtask

  initial begin
    clearDevs();
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    testSingle();
    testThree();
    testEdges();
    testIntr();
    testNoDevice();
    testDrop();
    testThree();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule